// File: doc/BRIEF.md
# Streaming Top-K Selector

This block takes an unbounded stream of unsigned keys, at most one per clock, and when the stream ends it returns the K largest keys it has seen, largest first. A stream may have any length. Its end is marked by a flag on its final key. Storage does not grow with the stream length. The block holds only a chain of log2(K) merge stages, which turns each consecutive group of K keys into a sorted run, plus a running best-K list that is updated by one extra comparator.

Each sorted run is merged against the retained best-K list, one key per cycle. The larger key is taken each time, and the merge stops after K keys, so everything that did not make the cut is dropped. The retained list lives in two register banks used in alternation: one is read while the new list is written into the other. When the stream length is not a multiple of K, the block itself appends zero keys to fill the last group. The final merge is also the readout: its K results leave the block with a valid flag, and the K-th also carries an end flag. While padding, draining and reading out, the block deasserts its ready output. It accepts the next stream in the cycle of the end flag.

Top module: `topk_stream_select`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` and `out_last_o` are 0.
- R2: After a stream ends, the block outputs the K largest keys of that stream as unsigned values, in non-increasing order.
- R3: Each stream yields exactly K output beats. `out_last_o` is 1 on the K-th beat only and never without `out_valid_o`. For a gap-free stream the K beats fall in K consecutive cycles.
- R4: If the stream holds fewer than K keys, the missing places are filled with the key value 0 at the end of the output. A length that is not a multiple of K gives the same result as the stream followed by zero keys up to the next multiple of K.
- R5: For a gap-free stream whose last key is accepted on clock edge T, let p = (K - N mod K) mod K. The first output beat is present in the cycle after edge T + p + 2*log2(K) + 1, and the last beat after edge T + p + 2*log2(K) + K.
- R6: `in_ready_o` drops in the cycle after the last key is accepted. It stays 0 until the cycle that shows `out_last_o`, in which it is 1 again. Keys, including end flags, that are presented while `in_ready_o` is 0 are ignored and appear in no output.
- R7: Consecutive streams are independent: no key from an earlier stream appears in the output of a later one.
- R8: Idle cycles (`in_valid_i` low) inside a stream do not change the result.
- R9: Equal keys are kept individually, so a value that occurs m times in the top K appears m times in the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A key is presented |
| in_key_i | input | W | Key value, unsigned |
| in_last_i | input | 1 | Presented key is the final one of its stream |
| in_ready_o | output | 1 | Block accepts keys; 0 while padding, draining and reading out |
| out_valid_o | output | 1 | Output beat present |
| out_key_o | output | W | Output key, non-increasing across a stream's beats |
| out_last_o | output | 1 | K-th output beat of the stream |

## Verification
For a gap-free stream, the first result is due 2*log2(K)+1 edges after the final zero pad. The final pad is p edges after the last key, or the last key itself when p is 0. The remaining K-1 results follow on consecutive edges, and the bench compares the negative-edge cycle number of the first and the last beat against those sums. Ready must be low on every negative edge between the accepting edge of the last key and the end-flag beat, and high on that beat. For streams with idle gaps only the content and order of the K results are compared, not their cycle. Junk keys with the end flag set are driven during every busy window of some streams. Any junk key that got in would surface as the maximum key in the next result.

// File: rtl/topk_pkg.sv
package topk_pkg;
  typedef enum logic [1:0] {
    PH_TAKE  = 2'd0,
    PH_PAD   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/topk_merge_stage.sv
// Merges pairs of descending runs of length 2**LVL into runs of 2**(LVL+1).
module topk_merge_stage #(
  parameter int unsigned W   = 16,
  parameter int unsigned LVL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_key_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_key_o
);
  localparam int unsigned RUN   = 1 << LVL;
  localparam int unsigned DEPTH = 2 * RUN;
  localparam int unsigned AW    = LVL + 1;
  localparam int unsigned CW    = LVL + 2;
  localparam logic [CW-1:0] RUN_C  = CW'(RUN);
  localparam logic [CW-1:0] WRAP_C = CW'(DEPTH - 1);

  logic [W-1:0] fa_mem [DEPTH];
  logic [W-1:0] fb_mem [DEPTH];
  logic [AW:0]  fa_wp, fa_rp, fb_wp, fb_rp;
  logic [CW-1:0] in_cnt, a_tk, b_tk, a_nx, b_nx;
  logic into_a, fa_ne, fb_ne, a_open, b_open, take_a, take_b;
  logic [W-1:0] a_head, b_head;

  assign into_a = in_cnt < RUN_C;
  assign fa_ne  = fa_wp != fa_rp;
  assign fb_ne  = fb_wp != fb_rp;
  assign a_head = fa_mem[fa_rp[AW-1:0]];
  assign b_head = fb_mem[fb_rp[AW-1:0]];
  assign a_open = a_tk < RUN_C;
  assign b_open = b_tk < RUN_C;

  // a head is only compared once both sides of the current pair have one
  always_comb begin
    take_a = a_open && fa_ne && (!b_open || (fb_ne && a_head >= b_head));
    take_b = b_open && fb_ne && (!a_open || (fa_ne && b_head > a_head));
    a_nx   = a_tk + CW'(take_a);
    b_nx   = b_tk + CW'(take_b);
    if (a_nx == RUN_C && b_nx == RUN_C) begin
      a_nx = '0;
      b_nx = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (in_valid_i) begin
      if (into_a) fa_mem[fa_wp[AW-1:0]] <= in_key_i;
      else        fb_mem[fb_wp[AW-1:0]] <= in_key_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fa_wp       <= '0;
      fa_rp       <= '0;
      fb_wp       <= '0;
      fb_rp       <= '0;
      in_cnt      <= '0;
      a_tk        <= '0;
      b_tk        <= '0;
      out_valid_o <= 1'b0;
      out_key_o   <= '0;
    end else begin
      if (in_valid_i) begin
        if (into_a) fa_wp <= fa_wp + 1'b1;
        else        fb_wp <= fb_wp + 1'b1;
        in_cnt <= (in_cnt == WRAP_C) ? '0 : in_cnt + 1'b1;
      end
      if (take_a) fa_rp <= fa_rp + 1'b1;
      if (take_b) fb_rp <= fb_rp + 1'b1;
      a_tk        <= a_nx;
      b_tk        <= b_nx;
      out_valid_o <= take_a | take_b;
      out_key_o   <= take_a ? a_head : b_head;
    end
  end
endmodule

// File: rtl/topk_block_sorter.sv
// Chain of log2(K) merge stages: every K consecutive keys leave as one descending run.
module topk_block_sorter #(
  parameter int unsigned W = 16,
  parameter int unsigned K = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_key_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_key_o
);
  localparam int unsigned LOGK = $clog2(K);

  logic         lvl_v [LOGK+1];
  logic [W-1:0] lvl_d [LOGK+1];

  assign lvl_v[0] = in_valid_i;
  assign lvl_d[0] = in_key_i;

  for (genvar g = 0; g < LOGK; g++) begin : g_stage
    topk_merge_stage #(.W(W), .LVL(g)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (lvl_v[g]),
      .in_key_i   (lvl_d[g]),
      .out_valid_o(lvl_v[g+1]),
      .out_key_o  (lvl_d[g+1])
    );
  end

  assign out_valid_o = lvl_v[LOGK];
  assign out_key_o   = lvl_d[LOGK];
endmodule

// File: rtl/topk_retain.sv
// Keeps the running best-K list; merges each sorted run against it, keeping K keys.
module topk_retain #(
  parameter int unsigned W = 16,
  parameter int unsigned K = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         blk_valid_i,
  input  logic [W-1:0] blk_key_i,
  input  logic         final_i,
  output logic         done_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_key_o,
  output logic         out_last_o
);
  localparam int unsigned IW = $clog2(K);
  localparam int unsigned CW = IW + 1;
  localparam logic [CW-1:0] FULL_C = CW'(K);
  localparam logic [IW-1:0] LAST_C = IW'(K - 1);

  logic [W-1:0]  run_buf [K];
  logic [W-1:0]  keep_buf [2][K];
  logic          cur;
  logic [CW-1:0] run_cnt;
  logic          run_used;
  logic [IW-1:0] oc, ri, bi, wr_idx;
  logic          emit, take_run, fin_emit;
  logic [W-1:0]  run_head, keep_head, win_key;

  assign wr_idx    = (run_cnt == FULL_C) ? '0 : run_cnt[IW-1:0];
  assign run_head  = run_buf[bi];
  assign keep_head = keep_buf[cur][ri];
  // merge waits only for the run side; the kept side is always complete
  assign emit      = !run_used && ({1'b0, bi} < run_cnt);
  assign take_run  = run_head > keep_head;
  assign win_key   = take_run ? run_head : keep_head;
  assign fin_emit  = emit && (oc == LAST_C);
  assign done_o    = fin_emit;

  always_ff @(posedge clk_i) begin
    if (blk_valid_i) run_buf[wr_idx] <= blk_key_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt  <= FULL_C;
      run_used <= 1'b1;
    end else begin
      if (fin_emit) run_used <= 1'b1;
      if (blk_valid_i) begin
        run_cnt <= (run_cnt == FULL_C) ? CW'(1) : run_cnt + 1'b1;
        if (run_cnt == FULL_C) run_used <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur <= 1'b0;
      oc  <= '0;
      ri  <= '0;
      bi  <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < K; i++) keep_buf[b][i] <= '0;
    end else if (emit) begin
      keep_buf[~cur][oc] <= win_key;
      if (fin_emit) begin
        oc  <= '0;
        ri  <= '0;
        bi  <= '0;
        cur <= ~cur;
        if (final_i) begin
          cur <= 1'b0;
          for (int b = 0; b < 2; b++)
            for (int i = 0; i < K; i++) keep_buf[b][i] <= '0;
        end
      end else begin
        oc <= oc + 1'b1;
        if (take_run) bi <= bi + 1'b1;
        else          ri <= ri + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_key_o   <= '0;
    end else begin
      out_valid_o <= emit && final_i;
      out_last_o  <= fin_emit && final_i;
      out_key_o   <= win_key;
    end
  end
endmodule

// File: rtl/topk_stream_select.sv
module topk_stream_select
  import topk_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned K = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_key_i,
  input  logic         in_last_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_key_o,
  output logic         out_last_o
);
  localparam int unsigned LOGK = $clog2(K);
  localparam int unsigned IW   = LOGK;
  localparam int unsigned PW   = $clog2(LOGK + 4) + 1;
  localparam logic [IW-1:0] LAST_C = IW'(K - 1);

  phase_e        ph;
  logic [IW-1:0] feed_cnt, pad_left;
  logic [PW-1:0] pend;
  logic          feed, blk_fed, final_run, merge_done;
  logic          srt_v;
  logic [W-1:0]  feed_key, srt_d;

  assign in_ready_o = (ph == PH_TAKE);
  assign feed       = (ph == PH_TAKE && in_valid_i) || (ph == PH_PAD);
  assign feed_key   = (ph == PH_PAD) ? '0 : in_key_i;
  assign blk_fed    = feed && (feed_cnt == LAST_C);
  assign final_run  = (ph == PH_DRAIN) && (pend == PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph       <= PH_TAKE;
      feed_cnt <= '0;
      pad_left <= '0;
      pend     <= '0;
    end else begin
      feed_cnt <= feed_cnt + IW'(feed);
      pend     <= pend + PW'(blk_fed) - PW'(merge_done);
      unique case (ph)
        PH_TAKE: begin
          if (in_valid_i && in_last_i) begin
            if (feed_cnt == LAST_C) ph <= PH_DRAIN;
            else begin
              ph       <= PH_PAD;
              pad_left <= LAST_C - feed_cnt;
            end
          end
        end
        PH_PAD: begin
          pad_left <= pad_left - 1'b1;
          if (pad_left == IW'(1)) ph <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (merge_done && final_run) ph <= PH_TAKE;
        end
        default: ph <= PH_TAKE;
      endcase
    end
  end

  topk_block_sorter #(.W(W), .K(K)) u_sorter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (feed),
    .in_key_i   (feed_key),
    .out_valid_o(srt_v),
    .out_key_o  (srt_d)
  );

  topk_retain #(.W(W), .K(K)) u_retain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_valid_i(srt_v),
    .blk_key_i  (srt_d),
    .final_i    (final_run),
    .done_o     (merge_done),
    .out_valid_o(out_valid_o),
    .out_key_o  (out_key_o),
    .out_last_o (out_last_o)
  );
endmodule

// File: rtl/topk_stream_select_chk.sv
module topk_stream_select_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_last_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic [W-1:0] out_key_o,
  input logic         out_last_o
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R3

  AST_DESCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o) && !$past(out_last_o)) |-> (out_key_o <= $past(out_key_o))); // R2

  AST_BUSY_DURING_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> !in_ready_o); // R6

  AST_READY_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> in_ready_o); // R6

  AST_STOP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o); // R6
endmodule

bind topk_stream_select topk_stream_select_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_last_i  (in_last_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_key_o  (out_key_o),
  .out_last_o (out_last_o)
);

// File: tb/tb_topk_stream_select.sv
module tb_topk_stream_select;
  localparam int W    = 16;
  localparam int K    = 8;
  localparam int LOGK = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_key = '0;
  logic         in_last = 1'b0;
  logic         in_ready, out_valid, out_last;
  logic [W-1:0] out_key;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;
  int unsigned kv [200];
  int unsigned ref_k [K];
  int unsigned got [K];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  topk_stream_select #(.W(W), .K(K)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_key_i   (in_key),
    .in_last_i  (in_last),
    .in_ready_o (in_ready),
    .out_valid_o(out_valid),
    .out_key_o  (out_key),
    .out_last_o (out_last)
  );

  function automatic int unsigned nxt_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: largest K of the keys plus zero padding, non-increasing.
  task automatic build_ref(input int n);
    int unsigned tmp [208];
    for (int i = 0; i < n + K; i++) tmp[i] = (i < n) ? kv[i] : 0;
    for (int j = 0; j < K; j++) begin
      int best = j;
      for (int i = j + 1; i < n + K; i++) if (tmp[i] > tmp[best]) best = i;
      ref_k[j] = tmp[best];
      tmp[best] = tmp[j];
      tmp[j] = ref_k[j];
    end
  endtask

  // mode: 0 full-range random, 1 values 0..3, 2 ascending, 3 descending, 4 all equal
  task automatic run_case(input int n, input int mode, input bit gaps, input bit junk,
                          input string req);
    int t_last, first_cyc, last_cyc, nout, pad;
    bit busy_ok, last_ok, done;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: kv[i] = nxt_rand() & 16'hFFFE;
        1: kv[i] = nxt_rand() & 3;
        2: kv[i] = (i * 37) & 16'hFFFF;
        3: kv[i] = (60000 - i * 11) & 16'hFFFF;
        default: kv[i] = 5;
      endcase
    end
    build_ref(n);
    pad = (K - (n % K)) % K;
    t_last = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        for (int g = 0; g < (i % 3); g++) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_key   = W'(kv[i]);
      in_last  = (i == n - 1);
      t_last   = cyc + 1;
    end
    nout = 0; first_cyc = -1; last_cyc = -1;
    busy_ok = 1'b1; last_ok = 1'b1; done = 1'b0;
    for (int w = 0; w < 400 && !done; w++) begin
      @(negedge clk);
      if (!out_last && in_ready) busy_ok = 1'b0;
      if (out_last && !in_ready) busy_ok = 1'b0;
      in_valid = junk && !in_ready;
      in_key   = 16'hFFFF;
      in_last  = 1'b1;
      if (out_valid) begin
        if (nout < K) got[nout] = out_key;
        if (nout == 0) first_cyc = cyc;
        last_cyc = cyc;
        if (out_last != (nout == K - 1)) last_ok = 1'b0;
        nout++;
        if (out_last) done = 1'b1;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(nout == K, "R3", "output beat count", nout, K);
    check(last_ok, "R3", "end flag only on K-th beat", last_ok, 1);
    check(busy_ok, "R6", "ready low while busy, high at end flag", busy_ok, 1);
    for (int i = 0; i < K && i < nout; i++)
      check(got[i] == ref_k[i], req, $sformatf("key %0d of n=%0d", i, n), got[i], ref_k[i]);
    if (!gaps) begin
      check(first_cyc == t_last + pad + 2 * LOGK + 1, "R5", "first beat cycle",
            first_cyc, t_last + pad + 2 * LOGK + 1);
      check(last_cyc == t_last + pad + 2 * LOGK + K, "R3", "last beat cycle (contiguous)",
            last_cyc, t_last + pad + 2 * LOGK + K);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_last == 1'b0, "R1", "out_last after reset", out_last, 0);
    run_case(8,  0, 1'b0, 1'b0, "R2");
    run_case(13, 0, 1'b0, 1'b0, "R4");
    run_case(5,  0, 1'b0, 1'b0, "R4");
    run_case(40, 1, 1'b0, 1'b0, "R9");
    run_case(64, 2, 1'b0, 1'b0, "R2");
    run_case(64, 3, 1'b0, 1'b0, "R2");
    run_case(33, 0, 1'b1, 1'b0, "R8");
    run_case(20, 1, 1'b0, 1'b1, "R7");   // small keys right after large ones
    run_case(1,  0, 1'b0, 1'b1, "R4");
    run_case(16, 4, 1'b0, 1'b0, "R9");
    run_case(50, 0, 1'b1, 1'b1, "R6");   // junk during busy must not leak
    run_case(24, 1, 1'b0, 1'b0, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule